// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a stream of bytes from a parallel back end into a bit-serial HDLC line. The back end raises `frame_valid` to open a frame and hands over bytes one at a time with `byte_wr` whenever `ready` is high. The transmitter puts an opening flag on the line, then the payload least significant bit first with zero insertion, then a 16-bit frame check sequence, then a closing flag. Between frames the line carries all-ones idle, one bit per enabled clock.

Every state change happens only on clocks where `tx_en` is high, so `tx_en` can pace the line from an external bit clock. A byte is due once the previous one has moved into the shifter. If the shifter finishes a byte, no new byte is waiting and `frame_valid` is still high, the frame is aborted. An abort sends a run of ones on the line and raises `abort_flag`. The back end can also force an abort with `abort_req`. The back end ends a frame cleanly by dropping `frame_valid` before the last byte has left the shifter.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `line_out` is 1 and `ready` and `abort_flag` are 0.
- R2: Outside a frame, the line emits a 1 on every enabled clock. A frame starts only on an enabled clock where `frame_valid` is high and `abort_flag` is low.
- R3: A frame on the line is the flag 0x7E, then each payload byte least significant bit first in write order, then the check sequence, then the flag 0x7E.
- R4: After five consecutive 1 bits of payload or check sequence, a 0 is inserted. Flag bits are never stuffed.
- R5: The check sequence is the ones' complement of a CRC over the payload bits in line order. The CRC uses x^16+x^12+x^5+1 (reflected constant 0x8408) with preset 0xFFFF. Its low byte is sent first, least significant bit first.
- R6: `ready` is high only while `frame_valid` is high, the one-byte holding register is empty, no abort is flagged, and the flag or payload is being sent. A write is taken when `byte_wr` and `ready` are both high, and `ready` is low on the next cycle.
- R7: When a byte has fully shifted out, the holding register is empty and `frame_valid` is low, the check sequence and closing flag follow, and the line returns to idle.
- R8: When a byte has fully shifted out, the holding register is empty and `frame_valid` is high, the frame is aborted. `abort_flag` rises on the same edge that puts the first of at least seven consecutive 1s on the line. A byte written within 7 clocks after `ready` rises is always in time.
- R9: `abort_req` on an enabled clock during the flag, payload, check sequence or closing flag aborts at once. `abort_flag` is high and `line_out` is 1 from that edge, and the holding register is emptied.
- R10: `abort_flag` stays high while `frame_valid` is high and clears on the first enabled clock where `frame_valid` is low. While it is high, no new frame starts.
- R11: On a clock where `tx_en` is low, no state changes and `line_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Clock enable; one line bit per enabled clock |
| frame_valid | input | 1 | Back end holds a frame open |
| byte_wr | input | 1 | Write strobe for `byte_in` |
| byte_in | input | 8 | Payload byte |
| abort_req | input | 1 | Request to abort the current frame |
| ready | output | 1 | Holding register can take a byte |
| abort_flag | output | 1 | An abort was sent in the current frame |
| line_out | output | 1 | Serial line, registered |

## Verification
`line_out` is registered, so the bit chosen on an enabled edge appears right after that edge. `abort_flag` rises on the same edge as the first abort 1, and `ready` falls on the edge that takes a write. `abort_flag` clears one enabled edge after `frame_valid` goes low. The bench drives inputs and samples outputs on the falling clock edge, so each of these one-edge results is read exactly one half period after the edge that causes it. Whole frames are captured bit by bit on enabled clocks only, then de-stuffed and decoded. Because of this, frame checks do not depend on the exact cycle a flag starts. The in-time write limit is tested at its last allowed clock: the write comes six falling edges after `ready` is first seen high.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int OCTET_W = 8;
  localparam logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_BODY,
    PH_FCS,
    PH_CLOSE,
    PH_ABORT
  } tx_phase_e;

endpackage

// File: rtl/hdlc_tx_crc.sv
// Bit-serial CRC, reflected form (LSB-first line order).
module hdlc_tx_crc #(
  parameter int             CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_R = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       init,
  input  logic       shift,
  input  logic       bit_in,
  output logic [7:0] fcs_lo_nx,   // complemented low byte including bit_in
  output logic [7:0] fcs_hi       // complemented high byte of held value
);

  logic [CRC_W-1:0] crc_q, crc_nx;
  logic             fb;

  always_comb begin
    fb     = crc_q[0] ^ bit_in;
    crc_nx = (crc_q >> 1) ^ (fb ? POLY_R : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (en) begin
      if (init)       crc_q <= PRESET;
      else if (shift) crc_q <= crc_nx;
    end
  end

  assign fcs_lo_nx = ~crc_nx[7:0];
  assign fcs_hi    = ~crc_q[15:8];

endmodule

// File: rtl/hdlc_tx_ones_run.sv
// Counts consecutive payload ones; flags when a stuffed zero is due.
module hdlc_tx_ones_run #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic bit_v,
  input  logic bit_in,
  output logic stuff_due
);

  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (clr)        run_d = '0;
    else if (bit_v) run_d = bit_in ? run_q + RW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  run_q <= '0;
    else if (en) run_q <= run_d;
  end

  assign stuff_due = (run_q == RW'(RUN));

endmodule

// File: rtl/hdlc_tx_holdreg.sv
// One-byte holding register between back end and shifter.
module hdlc_tx_holdreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         take,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full
);

  logic         full_d;
  logic [W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = dout;
    if (flush) begin
      full_d = 1'b0;
    end else if (wr) begin
      full_d = 1'b1;
      data_d = din;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else begin
      full <= full_d;
      dout <= data_d;
    end
  end

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int          ABORT_LEN  = 7,
  parameter int          STUFF_RUN  = 5,
  parameter logic [15:0] CRC_POLY_R = 16'h8408,
  parameter logic [15:0] CRC_PRESET = 16'hFFFF
) (
  input  logic         clk_tx,
  input  logic         rst_n,
  input  logic         tx_en,
  input  logic         frame_valid,
  input  logic         byte_wr,
  input  logic [7:0]   byte_in,
  input  logic         abort_req,
  output logic         ready,
  output logic         abort_flag,
  output logic         line_out
);

  localparam int SPAN  = (ABORT_LEN > OCTET_W) ? ABORT_LEN : OCTET_W;
  localparam int CNT_W = $clog2(SPAN);

  tx_phase_e          ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [OCTET_W-1:0] sh_q, sh_d;
  logic               fcs_hi_q, fcs_hi_d;
  logic               abt_q, abt_d;
  logic               line_q, line_d;

  logic               take, flush, go_abort, last_bit;
  logic               crc_init, crc_shift;
  logic               run_clr, run_bit, stuff_due;
  logic               hold_full;
  logic [OCTET_W-1:0] hold_byte;
  logic [7:0]         fcs_lo_nx, fcs_hi;

  assign ready = frame_valid && !hold_full && !abt_q &&
                 (ph_q == PH_OPEN || ph_q == PH_BODY);

  hdlc_tx_holdreg #(.W(OCTET_W)) u_hold (
    .clk   (clk_tx),
    .rst_n (rst_n),
    .wr    (byte_wr && ready),
    .take  (take && tx_en),
    .flush (flush && tx_en),
    .din   (byte_in),
    .dout  (hold_byte),
    .full  (hold_full)
  );

  hdlc_tx_crc #(.CRC_W(16), .POLY_R(CRC_POLY_R), .PRESET(CRC_PRESET)) u_crc (
    .clk       (clk_tx),
    .rst_n     (rst_n),
    .en        (tx_en),
    .init      (crc_init),
    .shift     (crc_shift),
    .bit_in    (sh_q[0]),
    .fcs_lo_nx (fcs_lo_nx),
    .fcs_hi    (fcs_hi)
  );

  hdlc_tx_ones_run #(.RUN(STUFF_RUN)) u_run (
    .clk       (clk_tx),
    .rst_n     (rst_n),
    .en        (tx_en),
    .clr       (run_clr),
    .bit_v     (run_bit),
    .bit_in    (sh_q[0]),
    .stuff_due (stuff_due)
  );

  // Next-state logic: one line bit per enabled clock.
  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    fcs_hi_d  = fcs_hi_q;
    line_d    = 1'b1;
    abt_d     = frame_valid ? abt_q : 1'b0;
    take      = 1'b0;
    flush     = 1'b0;
    go_abort  = 1'b0;
    crc_init  = 1'b0;
    crc_shift = 1'b0;
    run_clr   = 1'b0;
    run_bit   = 1'b0;
    last_bit  = (cnt_q == CNT_W'(OCTET_W - 1));

    case (ph_q)
      PH_IDLE: begin
        run_clr = 1'b1;
        if (frame_valid && !abt_q) begin
          ph_d  = PH_OPEN;
          cnt_d = '0;
        end
      end
      PH_OPEN: begin
        run_clr = 1'b1;
        line_d  = FLAG_OCTET[cnt_q[2:0]];
        cnt_d   = cnt_q + CNT_W'(1);
        if (last_bit) begin
          cnt_d = '0;
          if (hold_full) begin
            take     = 1'b1;
            sh_d     = hold_byte;
            crc_init = 1'b1;
            ph_d     = PH_BODY;
          end else if (frame_valid) begin
            go_abort = 1'b1;
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      PH_BODY: begin
        if (stuff_due) begin
          line_d  = 1'b0;
          run_clr = 1'b1;
        end else begin
          line_d    = sh_q[0];
          sh_d      = {1'b0, sh_q[OCTET_W-1:1]};
          run_bit   = 1'b1;
          crc_shift = 1'b1;
          cnt_d     = cnt_q + CNT_W'(1);
          if (last_bit) begin
            cnt_d = '0;
            if (hold_full) begin
              take = 1'b1;
              sh_d = hold_byte;
            end else if (frame_valid) begin
              go_abort = 1'b1;
            end else begin
              ph_d     = PH_FCS;
              sh_d     = fcs_lo_nx;
              fcs_hi_d = 1'b0;
            end
          end
        end
      end
      PH_FCS: begin
        if (stuff_due) begin
          line_d  = 1'b0;
          run_clr = 1'b1;
        end else begin
          line_d  = sh_q[0];
          sh_d    = {1'b0, sh_q[OCTET_W-1:1]};
          run_bit = 1'b1;
          cnt_d   = cnt_q + CNT_W'(1);
          if (last_bit) begin
            cnt_d = '0;
            if (!fcs_hi_q) begin
              sh_d     = fcs_hi;
              fcs_hi_d = 1'b1;
            end else begin
              ph_d = PH_CLOSE;
            end
          end
        end
      end
      PH_CLOSE: begin
        run_clr = 1'b1;
        if (stuff_due) begin
          line_d = 1'b0;
        end else begin
          line_d = FLAG_OCTET[cnt_q[2:0]];
          cnt_d  = cnt_q + CNT_W'(1);
          if (last_bit) begin
            cnt_d = '0;
            ph_d  = PH_IDLE;
          end
        end
      end
      PH_ABORT: begin
        run_clr = 1'b1;
        cnt_d   = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
          cnt_d = '0;
          ph_d  = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    if (abort_req && (ph_q == PH_OPEN || ph_q == PH_BODY ||
                      ph_q == PH_FCS  || ph_q == PH_CLOSE))
      go_abort = 1'b1;

    if (go_abort) begin
      ph_d      = PH_ABORT;
      cnt_d     = '0;
      line_d    = 1'b1;
      abt_d     = 1'b1;
      flush     = 1'b1;
      take      = 1'b0;
      run_clr   = 1'b1;
      run_bit   = 1'b0;
      crc_shift = 1'b0;
    end
  end

  // State registers, advanced only on enabled clocks.
  always_ff @(posedge clk_tx or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      fcs_hi_q <= 1'b0;
      abt_q    <= 1'b0;
      line_q   <= 1'b1;
    end else if (tx_en) begin
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      fcs_hi_q <= fcs_hi_d;
      abt_q    <= abt_d;
      line_q   <= line_d;
    end
  end

  assign abort_flag = abt_q;
  assign line_out   = line_q;

endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic frame_valid,
  input logic byte_wr,
  input logic abort_req,
  input logic ready,
  input logic abort_flag,
  input logic line_out,
  input logic in_idle
);

  logic rst_edge_seen;

  always @(posedge clk) rst_edge_seen <= !rst_n;

  always @(negedge clk) begin
    if (rst_edge_seen && !rst_n) begin
      assert_reset_state_R1: assert (line_out && !ready && !abort_flag)
        else $error("reset state wrong");
    end
  end

  assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && in_idle) |=> line_out);

  assert_wr_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && ready) |=> !ready);

  assert_abort_starts_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_flag) |-> line_out);

  assert_abort_req_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && abort_req && frame_valid && !in_idle) |=> abort_flag);

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !frame_valid && !abort_req) |=> !abort_flag);

  assert_abort_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |-> !ready);

  assert_freeze_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable(line_out));

endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk u_chk (
  .clk         (clk_tx),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .frame_valid (frame_valid),
  .byte_wr     (byte_wr),
  .abort_req   (abort_req),
  .ready       (ready),
  .abort_flag  (abort_flag),
  .line_out    (line_out),
  .in_idle     (ph_q == hdlc_tx_pkg::PH_IDLE)
);

// File: tb/hdlc_frame_tx_test.sv
`timescale 1ns/1ps
module hdlc_frame_tx_test;

  logic       clk_tx = 1'b0;
  logic       rst_n, tx_en, frame_valid, byte_wr, abort_req;
  logic [7:0] byte_in;
  logic       ready, abort_flag, line_out;

  int n_checks = 0;
  int n_errors = 0;

  bit         cap[$];
  logic [7:0] rx[$];
  int         n_drops;

  always #5 clk_tx = ~clk_tx;

  hdlc_frame_tx uut (
    .clk_tx      (clk_tx),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .frame_valid (frame_valid),
    .byte_wr     (byte_wr),
    .byte_in     (byte_in),
    .abort_req   (abort_req),
    .ready       (ready),
    .abort_flag  (abort_flag),
    .line_out    (line_out)
  );

  // Stimulus table: payload (byte 0 in low bits), length, tx_en gaps, write lateness.
  localparam int NROW = 5;
  localparam logic [31:0] T_DATA [NROW] = '{32'h0000_00A5, 32'h0000_7EFF,
                                           32'h00F8_1F00, 32'h01FF_FF3E, 32'h0000_3C5A};
  localparam int T_LEN  [NROW] = '{1, 2, 3, 4, 2};
  localparam int T_GAP  [NROW] = '{0, 0, 1, 0, 1};
  localparam int T_LATE [NROW] = '{0, 3, 0, 6, 0};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [31:0] d, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n * 8; k++) begin
      logic fb = c[0] ^ d[k];
      c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
    end
    return ~c;
  endfunction

  function automatic int stuffs_of(input logic [31:0] d, input int n, input logic [15:0] f);
    int run = 0, cnt = 0;
    for (int k = 0; k < n * 8 + 16; k++) begin
      logic b = (k < n * 8) ? d[k] : f[k - n * 8];
      if (b) begin
        run++;
        if (run == 5) begin cnt++; run = 0; end
      end else run = 0;
    end
    return cnt;
  endfunction

  // Returns 0 frame ok, 1 abort seen, 2 no closing/opening flag, 3 not byte aligned.
  task automatic decode(output int st);
    bit q[$];
    int i = 0, ones = 0;
    bit found = 0, done = 0;
    rx.delete();
    n_drops = 0;
    st = 2;
    while (i + 8 <= cap.size() && !found) begin
      if (cap[i] == 0 && cap[i+1] && cap[i+2] && cap[i+3] && cap[i+4] &&
          cap[i+5] && cap[i+6] && cap[i+7] == 0) found = 1;
      else i++;
    end
    if (!found) return;
    for (int j = i + 8; j < cap.size() && !done; j++) begin
      if (cap[j]) begin
        ones++;
        q.push_back(1'b1);
        if (ones >= 7) begin st = 1; return; end
      end else begin
        if (ones == 5) n_drops++;
        else if (ones == 6) begin
          for (int p = 0; p < 7; p++) void'(q.pop_back());
          done = 1;
        end else q.push_back(1'b0);
        ones = 0;
      end
    end
    if (!done) return;
    if (q.size() % 8 != 0) begin st = 3; return; end
    for (int k = 0; k < q.size() / 8; k++) begin
      logic [7:0] b;
      for (int m = 0; m < 8; m++) b[m] = q[8*k+m];
      rx.push_back(b);
    end
    st = 0;
  endtask

  task automatic writer(input logic [31:0] d, input int n, input int late);
    for (int k = 0; k < n; k++) begin
      do @(negedge clk_tx); while (!ready);
      repeat (late) @(negedge clk_tx);
      byte_in = d[8*k +: 8];
      byte_wr = 1'b1;
      @(negedge clk_tx);
      byte_wr = 1'b0;
      check(!ready, "R6", "ready after accepted write", ready, 0);
    end
    repeat (7) @(negedge clk_tx);
    frame_valid = 1'b0;
  endtask

  task automatic recorder(input int ncyc, input int gap);
    bit last = 1'b1;
    bit frozen_ok = 1'b1;
    cap.delete();
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk_tx);
      if (tx_en) begin
        cap.push_back(line_out);
        last = line_out;
      end else if (line_out != last) frozen_ok = 1'b0;
      tx_en = (gap != 0) ? (c % 3 != 2) : 1'b1;
    end
    tx_en = 1'b1;
    if (gap != 0) check(frozen_ok, "R11", "line held while tx_en low", frozen_ok, 1);
  endtask

  task automatic run_row(input int r);
    int st;
    logic [15:0] f;
    @(negedge clk_tx);
    frame_valid = 1'b1;
    fork
      writer(T_DATA[r], T_LEN[r], T_LATE[r]);
      recorder(T_LEN[r] * 24 + 60, T_GAP[r]);
    join
    decode(st);
    f = crc_of(T_DATA[r], T_LEN[r]);
    check(st == 0, "R7", $sformatf("row %0d frame closed", r), st, 0);
    check(rx.size() == T_LEN[r] + 2, "R3", $sformatf("row %0d byte count", r), rx.size(), T_LEN[r] + 2);
    if (rx.size() == T_LEN[r] + 2) begin
      for (int k = 0; k < T_LEN[r]; k++)
        check(rx[k] == T_DATA[r][8*k +: 8], "R3", $sformatf("row %0d byte %0d", r, k),
              rx[k], T_DATA[r][8*k +: 8]);
      check({rx[T_LEN[r]+1], rx[T_LEN[r]]} == f, "R5", $sformatf("row %0d fcs", r),
            {rx[T_LEN[r]+1], rx[T_LEN[r]]}, f);
    end
    check(n_drops == stuffs_of(T_DATA[r], T_LEN[r], f), "R4",
          $sformatf("row %0d stuffed zeros", r), n_drops, stuffs_of(T_DATA[r], T_LEN[r], f));
    check(!abort_flag, "R10", $sformatf("row %0d no abort", r), abort_flag, 0);
  endtask

  task automatic idle_check(input int n);
    bit ok = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk_tx);
      if (!line_out || ready) ok = 1'b0;
    end
    check(ok, "R2", "idle ones with frame_valid low", ok, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_tx);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int st;
    rst_n = 1'b0; tx_en = 1'b1; frame_valid = 1'b0;
    byte_wr = 1'b0; byte_in = 8'h00; abort_req = 1'b0;
    repeat (3) @(negedge clk_tx);
    check(line_out && !ready && !abort_flag, "R1", "reset state",
          {line_out, ready, abort_flag}, 3'b100);
    rst_n = 1'b1;
    idle_check(16);

    // Table-driven frames
    for (int r = 0; r < NROW; r++) begin
      run_row(r);
      idle_check(12);
    end

    // R8: underrun after one byte while frame_valid stays high
    @(negedge clk_tx);
    frame_valid = 1'b1;
    fork
      begin
        do @(negedge clk_tx); while (!ready);
        byte_in = 8'h00; byte_wr = 1'b1;
        @(negedge clk_tx);
        byte_wr = 1'b0;
      end
      recorder(60, 0);
    join
    decode(st);
    check(st == 1, "R8", "underrun produces abort run on line", st, 1);
    check(abort_flag, "R8", "abort_flag after underrun", abort_flag, 1);
    begin
      bit ok = 1'b1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk_tx);
        if (!line_out || ready || !abort_flag) ok = 1'b0;
      end
      check(ok, "R10", "flag held and no restart while frame_valid high", ok, 1);
    end
    frame_valid = 1'b0;
    @(negedge clk_tx);
    check(!abort_flag, "R10", "abort_flag clears after frame_valid low", abort_flag, 0);
    idle_check(10);

    // R9: forced abort during a frame
    frame_valid = 1'b1;
    do @(negedge clk_tx); while (!ready);
    byte_in = 8'hC3; byte_wr = 1'b1;
    @(negedge clk_tx);
    byte_wr = 1'b0;
    repeat (3) @(negedge clk_tx);
    check(!abort_flag, "R9", "no abort before request", abort_flag, 0);
    abort_req = 1'b1;
    @(negedge clk_tx);
    abort_req = 1'b0;
    check(abort_flag && line_out && !ready, "R9", "abort on request",
          {abort_flag, line_out, ready}, 3'b110);
    begin
      int run = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk_tx);
        if (line_out) run++;
      end
      check(run == 10, "R9", "ones after forced abort", run, 10);
    end
    frame_valid = 1'b0;
    @(negedge clk_tx);
    check(!abort_flag, "R10", "clear after forced abort", abort_flag, 0);

    // R1: reset in the middle of a frame
    frame_valid = 1'b1;
    repeat (12) @(negedge clk_tx);
    rst_n = 1'b0;
    #1;
    check(line_out && !ready && !abort_flag, "R1", "mid-frame reset",
          {line_out, ready, abort_flag}, 3'b100);
    frame_valid = 1'b0;
    @(negedge clk_tx);
    rst_n = 1'b1;
    idle_check(8);

    finish_run();
  end

endmodule